// File: doc/BRIEF.md
# Memory Bus Read/Write Cycle Sequencer

This block turns a single-cycle request from an 8-bit processor core into a timed external memory bus cycle on a 16-bit address bus. A read or write takes three bus states, T1, T2 and T3. Each strobe and data edge is placed on a chosen half of a chosen state. The block runs on a clock at twice the bus rate. Every bus state is therefore two fast cycles: a high half and a low half. A bus edge labelled "falling edge of Tn" is the fast edge between the two halves of Tn.

The core pulses `startReq` with the direction, address and write byte. The sequencer latches them and drives the active-low memory-request, read and write strobes. It then either captures the returned byte or drives the write byte with an output enable. A slow memory can pull `waitN` low to stretch the cycle by whole bus states between T2 and T3. The end of every access is marked by a one-fast-cycle `doneP`.

Top module: `mem_bus_seq`

## Requirements
- R1: Counting fast cycles from c=0, the cycle after the edge that accepts a start, a cycle with L inserted wait halves (L = 2 × wait states) lasts until c=5+L. `busAddr` shows the latched address from c=0 and does not change until the next accepted start.
- R2: In a read, `mreqN` and `rdN` are both low exactly in cycles c=1..4+L. They go high again at c=5+L, the low half of T3.
- R3: In a read, the byte on `busDin` is captured at the falling edge of T3. It appears on `rdData` from c=5+L and holds until the next read.
- R4: In a write, `rdN` stays high throughout. `mreqN` is low in c=1..4+L, and `wrN` is low in c=3..4+L. `wrN` is never low while `rdN` is low.
- R5: In a write, `busDoutEn` is high in c=1..5+L, which is half a bus state past the strobe release. `busDout` carries the latched write byte. `busDoutEn` is never high during a read or while idle.
- R6: `waitN` is sampled at the falling edge of T2 and of every wait state. Each low sample inserts one more bus state, two fast cycles, before T3. Strobes, address and data are held through it.
- R7: A start request arriving in any cycle c=0..5+L, including the done cycle, has no effect on the address, strobes or timing.
- R8: `doneP` is high for exactly one fast cycle, c=5+L.
- R9: While reset is asserted (`rstN` low), `mreqN`, `rdN` and `wrN` are high, and `busDoutEn` and `doneP` are low.
- R10: A write stores the core's byte at the addressed memory location. It is seen by a later read of the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, twice the bus rate |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Core request to begin an access |
| writeSel | input | 1 | 1 = write, 0 = read |
| coreAddr | input | 16 | Access address from the core |
| coreWdata | input | 8 | Byte to write |
| rdData | output | 8 | Byte captured by the last read |
| doneP | output | 1 | One-cycle end-of-access pulse |
| busAddr | output | 16 | Address lines |
| mreqN | output | 1 | Memory request, active low |
| rdN | output | 1 | Read strobe, active low |
| wrN | output | 1 | Write strobe, active low |
| busDout | output | 8 | Data driven to memory |
| busDoutEn | output | 1 | Enable for `busDout` |
| busDin | input | 8 | Data from memory |
| waitN | input | 1 | Wait request, active low |

## Verification
The read capture and the strobe release fall on the same fast edge, the falling edge of T3. The done pulse and a fresh start request can fall in the same cycle, c=5+L. The bench runs reads with zero, one and three wait states and checks `rdData` against its memory image in the done cycle, the cycle in which `mreqN` and `rdN` have just risen. It also raises `startReq` with a different address in the done cycle and in T1. It then requires the address to stay put in the following idle cycle, with no new `mreqN` falling edge there.

// File: rtl/mem_bus_seq_pkg.sv
package mem_bus_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_T1H, ST_T1L,
    ST_T2H, ST_T2L,
    ST_TWH, ST_TWL,
    ST_T3H, ST_T3L
  } busState_t;

  typedef struct packed {
    logic load;     // latch request fields
    logic capture;  // sample incoming read byte
  } seqCtl_t;

endpackage

// File: rtl/mem_bus_seq_ctrl.sv
module mem_bus_seq_ctrl
  import mem_bus_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startReq,
  input  logic    writeSel,
  input  logic    waitN,
  output seqCtl_t ctl,
  output logic    mreqN,
  output logic    rdN,
  output logic    wrN,
  output logic    doutEn,
  output logic    doneP
);

  busState_t state;
  logic      isWrite;
  logic      waitHit;
  logic      reqPhase;
  logic      wrPhase;
  logic      oePhase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      isWrite <= 1'b0;
      waitHit <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (startReq) begin
          state   <= ST_T1H;
          isWrite <= writeSel;
        end
        ST_T1H: state <= ST_T1L;
        ST_T1L: state <= ST_T2H;
        ST_T2H: begin
          state   <= ST_T2L;
          waitHit <= !waitN;   // falling edge of T2
        end
        ST_T2L: state <= waitHit ? ST_TWH : ST_T3H;
        ST_TWH: begin
          state   <= ST_TWL;
          waitHit <= !waitN;   // falling edge of a wait state
        end
        ST_TWL: state <= waitHit ? ST_TWH : ST_T3H;
        ST_T3H: state <= ST_T3L;
        ST_T3L: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    reqPhase = 1'b0;
    wrPhase  = 1'b0;
    oePhase  = 1'b0;
    unique case (state)
      ST_T1L:                 begin reqPhase = 1'b1; oePhase = 1'b1; end
      ST_T2H:                 begin reqPhase = 1'b1; oePhase = 1'b1; end
      ST_T2L, ST_TWH, ST_TWL,
      ST_T3H:                 begin reqPhase = 1'b1; wrPhase = 1'b1; oePhase = 1'b1; end
      ST_T3L:                 oePhase = 1'b1;
      default:                ;
    endcase
  end

  assign mreqN       = !reqPhase;
  assign rdN         = !(reqPhase && !isWrite);
  assign wrN         = !(wrPhase && isWrite);
  assign doutEn      = oePhase && isWrite;
  assign doneP       = (state == ST_T3L);
  assign ctl.load    = (state == ST_IDLE) && startReq;
  assign ctl.capture = (state == ST_T3H) && !isWrite;

  // R8: the done pulse never lasts two cycles
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    doneP |=> !doneP);

  // R7: a request seen mid-cycle does not reload the datapath
  p_ignore_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |-> !ctl.load);

  // R6: a low wait sample after T2 leads to a wait state
  p_wait_insert_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_T2H && !waitN) |=> ##1 (state == ST_TWH));

endmodule

// File: rtl/mem_bus_seq_dp.sv
module mem_bus_seq_dp
  import mem_bus_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtl_t           ctl,
  input  logic [ADDR_W-1:0] coreAddr,
  input  logic [DATA_W-1:0] coreWdata,
  input  logic [DATA_W-1:0] busDin,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busDout,
  output logic [DATA_W-1:0] rdData
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      rdataQ <= '0;
    end else begin
      if (ctl.load) begin
        addrQ  <= coreAddr;
        wdataQ <= coreWdata;
      end
      if (ctl.capture) rdataQ <= busDin;
    end
  end

  assign busAddr = addrQ;
  assign busDout = wdataQ;
  assign rdData  = rdataQ;

  // R3: the read byte changes only when a capture is commanded
  p_rdata_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.capture |=> $stable(rdataQ));

endmodule

// File: rtl/mem_bus_seq.sv
module mem_bus_seq
  import mem_bus_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              writeSel,
  input  logic [ADDR_W-1:0] coreAddr,
  input  logic [DATA_W-1:0] coreWdata,
  output logic [DATA_W-1:0] rdData,
  output logic              doneP,
  output logic [ADDR_W-1:0] busAddr,
  output logic              mreqN,
  output logic              rdN,
  output logic              wrN,
  output logic [DATA_W-1:0] busDout,
  output logic              busDoutEn,
  input  logic [DATA_W-1:0] busDin,
  input  logic              waitN
);

  seqCtl_t ctl;

  mem_bus_seq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .writeSel (writeSel),
    .waitN    (waitN),
    .ctl      (ctl),
    .mreqN    (mreqN),
    .rdN      (rdN),
    .wrN      (wrN),
    .doutEn   (busDoutEn),
    .doneP    (doneP)
  );

  mem_bus_seq_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .coreAddr  (coreAddr),
    .coreWdata (coreWdata),
    .busDin    (busDin),
    .busAddr   (busAddr),
    .busDout   (busDout),
    .rdData    (rdData)
  );

  // R4: read and write strobes never overlap
  p_no_rd_wr_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(!rdN && !wrN));

  // R4: write strobe only inside memory request
  p_wr_in_req_r4: assert property (@(posedge clk) disable iff (!rstN)
    !wrN |-> !mreqN);

  // R5: data is never driven while reading
  p_no_oe_read_r5: assert property (@(posedge clk) disable iff (!rstN)
    !rdN |-> !busDoutEn);

  // R5: enable outlives the request by half a bus state
  p_oe_tail_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(mreqN) && $past(busDoutEn)) |-> busDoutEn);

  // R1: address steady while request is held
  p_addr_stable_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!mreqN && $past(!mreqN)) |-> $stable(busAddr));

endmodule

// File: tb/mem_bus_seq_test.sv
module mem_bus_seq_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic        writeSel = 1'b0;
  logic [15:0] coreAddr = '0;
  logic [7:0]  coreWdata = '0;
  logic [7:0]  rdData;
  logic        doneP;
  logic [15:0] busAddr;
  logic        mreqN, rdN, wrN;
  logic [7:0]  busDout;
  logic        busDoutEn;
  logic [7:0]  busDin;
  logic        waitN = 1'b1;

  int testsRun = 0;
  int testsFailed = 0;
  int cycles = 0;
  bit finished = 1'b0;

  logic [7:0] mem    [256];
  logic [7:0] expMem [256];

  always #5 clk = ~clk;

  mem_bus_seq uut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .writeSel(writeSel),
    .coreAddr(coreAddr), .coreWdata(coreWdata), .rdData(rdData), .doneP(doneP),
    .busAddr(busAddr), .mreqN(mreqN), .rdN(rdN), .wrN(wrN),
    .busDout(busDout), .busDoutEn(busDoutEn), .busDin(busDin), .waitN(waitN)
  );

  // behavioural memory
  assign busDin = !rdN ? mem[busAddr[7:0]] : 8'h00;
  always @(posedge clk) begin
    if (rstN && !mreqN && !wrN) mem[busAddr[7:0]] <= busDout;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  // one access, checked on every fast cycle from c=0 to the idle cycle
  task automatic access(input bit wr, input logic [15:0] a, input logic [7:0] d,
                        input int nWait, input bit poke);
    int lastC;
    int l;
    l = 2 * nWait;
    lastC = 6 + l;
    @(negedge clk);
    startReq  = 1'b1;
    writeSel  = wr;
    coreAddr  = a;
    coreWdata = d;
    waitN     = 1'b1;
    for (int c = 0; c <= lastC; c++) begin
      @(negedge clk);
      // stimulus for the edge ending cycle c
      waitN = (c < 2 + l) ? 1'b0 : 1'b1;
      if (poke && (c == 1 || c == 5 + l)) begin
        startReq = 1'b1;
        coreAddr = ~a;
        writeSel = ~wr;
      end else begin
        startReq = 1'b0;
      end
      // expected values for cycle c
      begin
        bit inReq, inWr, inOe, isDone;
        inReq  = (c >= 1 && c <= 4 + l);
        inWr   = wr && (c >= 3 && c <= 4 + l);
        inOe   = wr && (c >= 1 && c <= 5 + l);
        isDone = (c == 5 + l);
        chk(busAddr == a, "R1 addr", busAddr, a);
        chk(mreqN == !inReq, wr ? "R4 mreqN" : "R2 mreqN", mreqN, !inReq);
        chk(rdN == !(inReq && !wr), wr ? "R4 rdN" : "R2 rdN", rdN, !(inReq && !wr));
        chk(wrN == !inWr, "R4 wrN", wrN, !inWr);
        chk(busDoutEn == inOe, "R5 busDoutEn", busDoutEn, inOe);
        if (inOe) chk(busDout == d, "R5 busDout", busDout, d);
        chk(doneP == isDone, "R8 doneP", doneP, isDone);
        if (!wr && isDone)
          chk(rdData == expMem[a[7:0]], "R3 rdData", rdData, expMem[a[7:0]]);
        if (poke && c == lastC)
          chk(busAddr == a && mreqN, "R7 ignored start", busAddr, a);
      end
    end
    if (wr) expMem[a[7:0]] = d;
    startReq = 1'b0;
    waitN    = 1'b1;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i]    = 8'(i * 7 + 3);
      expMem[i] = 8'(i * 7 + 3);
    end
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(mreqN && rdN && wrN, "R9 strobes in reset", {mreqN, rdN, wrN}, 3'b111);
    chk(!busDoutEn && !doneP, "R9 oe/done in reset", {busDoutEn, doneP}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(mreqN && !busDoutEn, "R9 idle after reset", {mreqN, busDoutEn}, 2'b10);

    access(1'b0, 16'h1234, 8'h00, 0, 1'b0);   // plain read, R2 R3
    access(1'b1, 16'hA055, 8'h5A, 0, 1'b0);   // plain write, R4 R5
    access(1'b0, 16'hBE55, 8'h00, 1, 1'b0);   // R10 read back with one wait, R6
    access(1'b1, 16'h0010, 8'hC3, 3, 1'b0);   // write with three waits, R6
    access(1'b0, 16'h7710, 8'h00, 3, 1'b1);   // R10 read back, R7 pokes
    access(1'b1, 16'hFFFF, 8'h81, 2, 1'b1);   // write at top address, R7 pokes
    access(1'b0, 16'h00FF, 8'h00, 0, 1'b1);   // R10 read back top byte
    access(1'b0, 16'h0000, 8'h00, 1, 1'b0);   // bottom address
    repeat (2) @(negedge clk);
    chk(mreqN && !doneP && !busDoutEn, "R7 stays idle", {mreqN, doneP, busDoutEn}, 3'b100);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    while (!finished) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !finished) begin
        testsRun++;
        testsFailed++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
        $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
        $finish;
      end
    end
  end

endmodule